// File: doc/BRIEF.md
# Strap Latch and Frequency Select Controller

This block sits between the pads of a clock synthesizer and its PLL control. Several clock pins double as configuration inputs while power comes up: five frequency-select straps, one strap for the interrupt-controller clock rate, and one strap that picks between 24 MHz and 48 MHz for the super-I/O clock. The block counts a fixed power-up window after the power-on reset is released. On the edge that closes the window it samples the straps once. From then on the pins are clock outputs, and their levels no longer matter to this block.

After capture, the block produces a 6-bit index into the synthesizer's 64-entry frequency table. A mode bit in the frequency-select register chooses the source of the index. In hardware mode the index comes from the latched straps, which reach only the lower 32 entries. In software mode the index is assembled from six bits spread across the same register. Each new index goes to the PLL through a request/acknowledge handshake, so the PLL never sees an index that is half written. The block also registers an enable for every clock output from the configuration bytes, gated by an active-low power-down pin, and forwards the two spread-spectrum controls.

Top module: `fsel_top`

## Requirements
- R1: The straps are sampled on exactly the PorCycles-th rising clock edge after the power-on reset is released, and only then. Strap pin changes after that edge have no effect on `apicSel`, `sel24m`, `freqIdx` or `idxReq`.
- R2: Until the edge after capture, every output enable, `spreadEn` and `idxReq` stays 0.
- R3: When `cfgFsel` bit 3 is 0, the selected index is {0, FS4, FS3, FS2, FS1, FS0}, taken from the latched `strapFs[4:0]` (FS0 is bit 0).
- R4: When `cfgFsel` bit 3 is 1, the selected index is {cfgFsel[1], cfgFsel[2], cfgFsel[7:4]}: index bit 5 comes from register bit 1, index bit 4 from bit 2, and index bits 3..0 from bits 7..4.
- R5: One edge after capture, the block issues a request carrying the selected index. Later it issues one request whenever the selected index differs from `freqIdx` and no request is open. `freqIdx` loads on the edge that raises `idxReq` and is held stable while `idxReq` is high. `idxReq` falls on the edge at which `idxAck` is sampled high.
- R6: One edge after a register change, each enable equals its bit, with 1 meaning active. `sdramEn[7:0]` = `cfgSdram`, `sdramEn[8]` = `cfgCtl[0]`, `pciEn` = `cfgPci`, `cpuEn[1:0]` = `cfgCore[2:1]`, `apicEn` = `cfgCore[3]`, `ck66En[0]` = `cfgCore[6]`, `ck66En[1]` = `cfgCore[5]`, `refEn` = `cfgCtl[6]`, `ck2448En` = `cfgCtl[2]`, `usb48En` = `cfgCtl[1]`.
- R7: While `pwrDownN` is 0, every enable is 0 from the following edge. Enables return to their register values one edge after `pwrDownN` returns to 1.
- R8: One edge after a change, `spreadEn` follows `cfgSpread[1]` (1 = modulation on) and `spreadWide` follows `cfgSpread[7]` (0 = ±0.5 %, 1 = ±0.75 % center spread).
- R9: `apicSel` holds the latched interrupt-controller strap. `sel24m` holds the latched super-I/O strap: 1 selects 24 MHz and 0 selects 48 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| strapFs | input | 5 | Frequency-select strap pins, FS0 at bit 0 |
| strapApic | input | 1 | Interrupt-controller rate strap pin |
| strapSio | input | 1 | Super-I/O clock rate strap pin |
| cfgCtl | input | 8 | Control byte: reference, 24/48, 48 MHz pair, SDRAM8 enables |
| cfgSdram | input | 8 | SDRAM0..7 enables |
| cfgPci | input | 8 | PCI clock 0..7 enables |
| cfgCore | input | 8 | CPU, interrupt-controller and 66 MHz enables |
| cfgFsel | input | 8 | Index source mode and software index bits |
| cfgSpread | input | 8 | Spread enable (bit 1) and spread width (bit 7) |
| pwrDownN | input | 1 | Power-down, active low |
| idxAck | input | 1 | Acknowledge from the synthesizer |
| freqIdx | output | 6 | Frequency-table index presented to the synthesizer |
| idxReq | output | 1 | Index change request |
| apicSel | output | 1 | Latched interrupt-controller rate select |
| sel24m | output | 1 | Latched 24 MHz (1) / 48 MHz (0) select |
| spreadEn | output | 1 | Spread-spectrum modulation enable |
| spreadWide | output | 1 | Spread width select |
| sdramEn | output | 9 | SDRAM clock enables |
| pciEn | output | 8 | PCI clock enables |
| cpuEn | output | 2 | CPU clock enables |
| apicEn | output | 1 | Interrupt-controller clock enable |
| ck66En | output | 2 | 66 MHz clock enables |
| refEn | output | 1 | Reference clock enable |
| ck2448En | output | 1 | 24/48 MHz clock enable |
| usb48En | output | 1 | Enable for the 48 MHz pair |

## Verification
The latched straps show up on the ports right after the PorCycles-th edge following reset release. The enables, the spread bits and the first request follow one edge later. After that, every register or power-down change reaches its output on the next edge, and `idxReq` falls on the edge after `idxAck` is seen high. The bench drives at falling edges and samples at the falling edge one cycle after the change that causes an output, so each result is read exactly one register stage after its cause. The handshake monitor checks the index against a queue of expected indices when it sees a request. It holds `idxAck` low for a chosen number of cycles, and it checks each cycle that the index does not move.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int IdxW   = 6;
  localparam int HwIdxW = 5;
  localparam int NumEn  = 25;

  typedef struct packed {
    logic live;     // straps captured, outputs may run
    logic capture;  // sample strap pins this edge
    logic issue;    // load new index and raise request
  } ctrlStb_t;
endpackage

// File: rtl/fsel_ctl.sv
module fsel_ctl
  import fsel_pkg::*;
#(
  parameter int PorCycles = 16
) (
  input  logic     clk,
  input  logic     porRstN,
  input  logic     idxDiffers,
  input  logic     idxAck,
  output ctrlStb_t stb,
  output logic     idxReq
);
  localparam int CntW = (PorCycles > 1) ? $clog2(PorCycles) : 1;
  localparam logic [CntW-1:0] LastCnt = CntW'(PorCycles - 1);

  logic [CntW-1:0] porCnt;
  logic captured;
  logic announced;

  always_comb begin
    stb.live    = captured;
    stb.capture = !captured && (porCnt == LastCnt);
    stb.issue   = captured && !idxReq && (!announced || idxDiffers);
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      porCnt    <= '0;
      captured  <= 1'b0;
      announced <= 1'b0;
      idxReq    <= 1'b0;
    end else begin
      if (!captured) begin
        if (stb.capture) captured <= 1'b1;
        else             porCnt   <= porCnt + 1'b1;
      end
      if (stb.issue) begin
        idxReq    <= 1'b1;
        announced <= 1'b1;
      end else if (idxReq && idxAck) begin
        idxReq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsel_dp.sv
module fsel_dp
  import fsel_pkg::*;
(
  input  logic             clk,
  input  logic             porRstN,
  input  ctrlStb_t         stb,
  input  logic [HwIdxW-1:0] strapFs,
  input  logic             strapApic,
  input  logic             strapSio,
  input  logic [7:0]       cfgCtl,
  input  logic [7:0]       cfgSdram,
  input  logic [7:0]       cfgPci,
  input  logic [7:0]       cfgCore,
  input  logic [7:0]       cfgFsel,
  input  logic [7:0]       cfgSpread,
  input  logic             pwrDownN,
  output logic [IdxW-1:0]  freqIdx,
  output logic             idxDiffers,
  output logic             apicSel,
  output logic             sel24m,
  output logic             spreadEn,
  output logic             spreadWide,
  output logic [NumEn-1:0] enVec
);
  logic [HwIdxW-1:0] fsLat;
  logic [IdxW-1:0]   hwIdx, swIdx, selIdx;
  logic [NumEn-1:0]  rawEn, gateEn;
  logic              unusedCfg;

  assign unusedCfg = ^{cfgFsel[0], cfgSpread[6:2], cfgSpread[0],
                       cfgCtl[7], cfgCtl[5:3], cfgCore[7], cfgCore[4], cfgCore[0]};

  always_comb begin
    hwIdx      = {{(IdxW-HwIdxW){1'b0}}, fsLat};
    swIdx      = {cfgFsel[1], cfgFsel[2], cfgFsel[7:4]};
    selIdx     = cfgFsel[3] ? swIdx : hwIdx;
    idxDiffers = (selIdx != freqIdx);
    rawEn      = {cfgCtl[1], cfgCtl[2], cfgCtl[6],
                  cfgCore[5], cfgCore[6], cfgCore[3], cfgCore[2:1],
                  cfgPci, cfgCtl[0], cfgSdram};
  end

  for (genvar i = 0; i < NumEn; i++) begin : g_gate
    assign gateEn[i] = stb.live & pwrDownN & rawEn[i];
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      fsLat   <= '0;
      apicSel <= 1'b0;
      sel24m  <= 1'b0;
    end else if (stb.capture) begin
      fsLat   <= strapFs;
      apicSel <= strapApic;
      sel24m  <= strapSio;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      freqIdx    <= '0;
      enVec      <= '0;
      spreadEn   <= 1'b0;
      spreadWide <= 1'b0;
    end else begin
      if (stb.issue) freqIdx <= selIdx;
      enVec      <= gateEn;
      spreadEn   <= stb.live & cfgSpread[1];
      spreadWide <= cfgSpread[7];
    end
  end
endmodule

// File: rtl/fsel_top.sv
module fsel_top
  import fsel_pkg::*;
#(
  parameter int PorCycles = 16
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic [4:0] strapFs,
  input  logic       strapApic,
  input  logic       strapSio,
  input  logic [7:0] cfgCtl,
  input  logic [7:0] cfgSdram,
  input  logic [7:0] cfgPci,
  input  logic [7:0] cfgCore,
  input  logic [7:0] cfgFsel,
  input  logic [7:0] cfgSpread,
  input  logic       pwrDownN,
  input  logic       idxAck,
  output logic [5:0] freqIdx,
  output logic       idxReq,
  output logic       apicSel,
  output logic       sel24m,
  output logic       spreadEn,
  output logic       spreadWide,
  output logic [8:0] sdramEn,
  output logic [7:0] pciEn,
  output logic [1:0] cpuEn,
  output logic       apicEn,
  output logic [1:0] ck66En,
  output logic       refEn,
  output logic       ck2448En,
  output logic       usb48En
);
  ctrlStb_t         stb;
  logic             idxDiffers;
  logic [NumEn-1:0] enVec;

  fsel_ctl #(.PorCycles(PorCycles)) u_ctl (
    .clk(clk), .porRstN(porRstN), .idxDiffers(idxDiffers),
    .idxAck(idxAck), .stb(stb), .idxReq(idxReq)
  );

  fsel_dp u_dp (
    .clk(clk), .porRstN(porRstN), .stb(stb),
    .strapFs(strapFs), .strapApic(strapApic), .strapSio(strapSio),
    .cfgCtl(cfgCtl), .cfgSdram(cfgSdram), .cfgPci(cfgPci),
    .cfgCore(cfgCore), .cfgFsel(cfgFsel), .cfgSpread(cfgSpread),
    .pwrDownN(pwrDownN), .freqIdx(freqIdx), .idxDiffers(idxDiffers),
    .apicSel(apicSel), .sel24m(sel24m), .spreadEn(spreadEn),
    .spreadWide(spreadWide), .enVec(enVec)
  );

  assign sdramEn  = enVec[8:0];
  assign pciEn    = enVec[16:9];
  assign cpuEn    = enVec[18:17];
  assign apicEn   = enVec[19];
  assign ck66En   = enVec[21:20];
  assign refEn    = enVec[22];
  assign ck2448En = enVec[23];
  assign usb48En  = enVec[24];
endmodule

// File: rtl/fsel_chk.sv
module fsel_chk (
  input logic       clk,
  input logic       porRstN,
  input logic       pwrDownN,
  input logic       idxAck,
  input logic [5:0] freqIdx,
  input logic       idxReq,
  input logic       apicSel,
  input logic       sel24m,
  input logic [8:0] sdramEn,
  input logic [7:0] pciEn,
  input logic [1:0] cpuEn,
  input logic       apicEn,
  input logic [1:0] ck66En,
  input logic       refEn,
  input logic       ck2448En,
  input logic       usb48En
);
  // R5: open request keeps its index until acknowledged
  p_idx_hold_r5: assert property (@(posedge clk) disable iff (!porRstN)
    (idxReq && !idxAck) |=> (idxReq && $stable(freqIdx)));

  // R5: acknowledge closes the request on the next edge
  p_req_drop_r5: assert property (@(posedge clk) disable iff (!porRstN)
    (idxReq && idxAck) |=> !idxReq);

  // R5: the index only moves together with a new request
  p_idx_move_r5: assert property (@(posedge clk) disable iff (!porRstN)
    !$stable(freqIdx) |-> $rose(idxReq));

  // R7: power-down silences every clock enable
  p_pd_off_r7: assert property (@(posedge clk) disable iff (!porRstN)
    !pwrDownN |=> (sdramEn == '0 && pciEn == '0 && cpuEn == '0 && !apicEn &&
                   ck66En == '0 && !refEn && !ck2448En && !usb48En));

  // R1, R9: once clocks run, the latched selects never change
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!porRstN)
    (|pciEn) |=> ($stable(apicSel) && $stable(sel24m)));
endmodule

bind fsel_top fsel_chk u_chk (.*);

// File: tb/fsel_top_bench.sv
module fsel_top_bench;
  localparam int PorCycles = 16;

  logic       clk = 1'b0;
  logic       porRstN = 1'b0;
  logic [4:0] strapFs = 5'b01101;
  logic       strapApic = 1'b1;
  logic       strapSio = 1'b1;
  logic [7:0] cfgCtl = 8'h47, cfgSdram = 8'hFF, cfgPci = 8'hFF;
  logic [7:0] cfgCore = 8'h6E, cfgFsel = 8'h00, cfgSpread = 8'h00;
  logic       pwrDownN = 1'b1;
  logic       idxAck = 1'b0;
  logic [5:0] freqIdx;
  logic       idxReq, apicSel, sel24m, spreadEn, spreadWide;
  logic [8:0] sdramEn;
  logic [7:0] pciEn;
  logic [1:0] cpuEn, ck66En;
  logic       apicEn, refEn, ck2448En, usb48En;

  int errors = 0;
  int checks = 0;
  int ackDelay = 0;
  bit done = 1'b0;
  logic [5:0] expQ[$];

  always #5 clk = ~clk;

  fsel_top #(.PorCycles(PorCycles)) u_fsel_top (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushExp(logic [5:0] idx);
    expQ.push_back(idx);
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0 || idxReq) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops expected index on each request, holds ack off for ackDelay
  initial begin
    forever begin
      @(negedge clk);
      if (porRstN && idxReq) begin
        logic [5:0] seen;
        seen = freqIdx;
        if (expQ.size() == 0) check("R5 unexpected request", {26'd0, seen}, 32'hFFFF_FFFF);
        else check("R5 index", {26'd0, seen}, {26'd0, expQ.pop_front()});
        for (int k = 0; k < ackDelay; k++) begin
          @(negedge clk);
          check("R5 stable while open", {26'd0, freqIdx}, {26'd0, seen});
        end
        idxAck = 1'b1;
        @(negedge clk);
        idxAck = 1'b0;
        check("R5 request closed", {31'd0, idxReq}, 32'd0);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pushExp(6'd13);           // R3: straps 01101, hardware index
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    repeat (PorCycles - 1) @(posedge clk);
    @(negedge clk);
    check("R1 not yet sampled", {31'd0, apicSel}, 32'd0);
    check("R2 enables off", {23'd0, sdramEn}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R9 apicSel latched", {31'd0, apicSel}, 32'd1);
    check("R9 sel24m latched", {31'd0, sel24m}, 32'd1);
    check("R2 enables off at capture", {24'd0, pciEn}, 32'd0);
    check("R2 no request at capture", {31'd0, idxReq}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R6 power-up sdram", {23'd0, sdramEn}, 32'h1FF);
    check("R6 power-up core", {26'd0, cpuEn, apicEn, ck66En, refEn}, 32'h3F);
    waitDrain();

    // R1: strap pins toggled after capture are ignored
    strapFs = 5'b10010; strapApic = 1'b0; strapSio = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 no request", {31'd0, idxReq}, 32'd0);
    check("R1 apicSel held", {31'd0, apicSel}, 32'd1);
    check("R1 sel24m held", {31'd0, sel24m}, 32'd1);
    check("R1 index held", {26'd0, freqIdx}, 32'd13);

    // R4: software index assembly
    pushExp(6'd45); cfgFsel = 8'hDA; waitDrain();
    pushExp(6'd19); cfgFsel = 8'h3C; waitDrain();
    // R3: back to hardware uses latched straps, not the pins
    pushExp(6'd13); cfgFsel = 8'h00; waitDrain();

    // R5: change during an open request, slow acknowledge
    ackDelay = 4;
    pushExp(6'd45); pushExp(6'd19);
    cfgFsel = 8'hDA;
    repeat (3) @(negedge clk);
    cfgFsel = 8'h3C;
    waitDrain();
    ackDelay = 0;
    check("R5 final index", {26'd0, freqIdx}, 32'd19);

    // R6: enable mapping
    cfgSdram = 8'hA5; cfgPci = 8'h3C; cfgCtl = 8'h41; cfgCore = 8'h4A;
    @(posedge clk); @(negedge clk);
    check("R6 sdram", {23'd0, sdramEn}, 32'h1A5);
    check("R6 pci", {24'd0, pciEn}, 32'h3C);
    check("R6 cpu", {30'd0, cpuEn}, 32'd1);
    check("R6 apic", {31'd0, apicEn}, 32'd1);
    check("R6 ck66", {30'd0, ck66En}, 32'd1);
    check("R6 ref/2448/usb", {29'd0, refEn, ck2448En, usb48En}, 32'b100);

    // R7: power-down
    pwrDownN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 pd sdram", {23'd0, sdramEn}, 32'd0);
    check("R7 pd misc", {22'd0, pciEn, apicEn, refEn}, 32'd0);
    pwrDownN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 restore", {23'd0, sdramEn}, 32'h1A5);

    // R8: spread controls
    cfgSpread = 8'h82;
    @(posedge clk); @(negedge clk);
    check("R8 wide on", {30'd0, spreadEn, spreadWide}, 32'b11);
    cfgSpread = 8'h02;
    @(posedge clk); @(negedge clk);
    check("R8 narrow on", {30'd0, spreadEn, spreadWide}, 32'b10);
    cfgSpread = 8'h00;
    @(posedge clk); @(negedge clk);
    check("R8 off", {30'd0, spreadEn, spreadWide}, 32'b00);

    repeat (4) @(negedge clk);
    check("R5 queue empty", expQ.size(), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule